// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Bank

This block collects up to 32 hardware interrupt requests into a sticky cause register and presents them to software through a small bank of word registers on a plain register bus (address, write strobe, write data, read strobe, read data). Each source owns the same bit position in every register of the bank. Software chooses at run time, bit by bit, whether a pending cause is cleared by writing a one to it or cleared as a side effect of reading it.

A mask register blocks individual causes from reaching the single interrupt output. The mask can be written whole, or adjusted bit by bit through set and clear aliases, so one agent can change its own bits without a read-modify-write. A masked-cause view shows only the causes that are not blocked, and accesses through that view clear only the causes it shows. Software can also raise any cause itself through a write-only set register, which is useful for testing handlers and for passing events between agents.

The interrupt output is a registered OR of all unmasked pending causes and is meant to drive the upstream interrupt line directly.

Top module: `intc_bank`

## Requirements
- R1: After reset the control register and the cause register read 0, the mask reads all ones, and the interrupt output is 0.
- R2: Registers sit at byte offsets 0x00 control, 0x04 cause, 0x08 masked cause, 0x0C cause-set, 0x10 mask, 0x14 mask-set, 0x18 mask-clear; offsets 0x0C, 0x14, 0x18, 0x1C and any address with bit 1 or bit 0 set read as 0, and writes to 0x1C or to a misaligned address change nothing.
- R3: A source input that is 1 in any cycle sets its cause bit at that clock edge, and the bit stays set after the source returns to 0 until software clears it.
- R4: With control bit b equal to 0, writing 1 to bit b at 0x04 clears cause bit b; writing 0 and reading leave it set.
- R5: With control bit b equal to 1, a read strobe at 0x04 returns cause bit b and then clears it; writing 1 to it does not clear it.
- R6: A read at 0x08 returns cause AND NOT mask.
- R7: Reads and writes at 0x08 clear cause bits under the same per-bit rule as 0x04, but only bits whose mask bit is 0; masked causes are left pending.
- R8: Writing 1 to bit b at 0x0C sets cause bit b; zero bits have no effect.
- R9: The mask at 0x10 is read and written directly; a 1 blocks that cause from the masked view and from the interrupt output.
- R10: Writing 1 to bit b at 0x14 sets mask bit b, writing 1 to bit b at 0x18 clears it, and zero bits in those writes leave the mask unchanged.
- R11: A source asserted in the same cycle as a software clear (write-one or read) of the same bit wins, and the cause bit remains set.
- R12: The interrupt output equals the OR of cause AND NOT mask as it stood one clock earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | N_SRC | Hardware interrupt requests, one per cause bit |
| addr_i | input | ADDR_W | Byte address of the register access |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | N_SRC | Write data |
| rd_en_i | input | 1 | Read strobe; also triggers clear-on-read |
| rd_data_o | output | N_SRC | Read data, valid in the cycle of the read strobe, 0 when no read |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest situation to produce is a clear through the masked view where control and mask bits disagree per bit, so that in one access some causes clear by read, some by write, and some stay pending only because they are masked. The bench sets a control pattern and a mask pattern that cover all four combinations across neighbouring bits, then walks a single cause through every bit position, clearing it through both views in turn. A second corner, a source firing in the very cycle software clears it, is produced by driving the source input together with the clearing access.

// File: rtl/intc_pkg.sv
package intc_pkg;

  typedef enum logic [2:0] {
    REG_CTL    = 3'd0,
    REG_CAUSE  = 3'd1,
    REG_MCAUSE = 3'd2,
    REG_CSET   = 3'd3,
    REG_MASK   = 3'd4,
    REG_MSET   = 3'd5,
    REG_MCLR   = 3'd6,
    REG_NONE   = 3'd7
  } reg_sel_e;

  typedef struct packed {
    logic wr_ctl;
    logic wr_cause;
    logic wr_mcause;
    logic wr_cset;
    logic wr_mask;
    logic wr_mset;
    logic wr_mclr;
    logic rd_cause;
    logic rd_mcause;
  } strobe_t;

endpackage

// File: rtl/intc_decode.sv
module intc_decode
  import intc_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  output reg_sel_e          sel_o,
  output strobe_t           st_o
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              hit;

  assign word  = addr_i[ADDR_W-1:2];
  assign hit   = (addr_i[1:0] == 2'b00) && (word < WORD_W'(7));
  assign sel_o = hit ? reg_sel_e'(word[2:0]) : REG_NONE;

  always_comb begin
    st_o           = '0;
    st_o.wr_ctl    = wr_en_i && sel_o == REG_CTL;
    st_o.wr_cause  = wr_en_i && sel_o == REG_CAUSE;
    st_o.wr_mcause = wr_en_i && sel_o == REG_MCAUSE;
    st_o.wr_cset   = wr_en_i && sel_o == REG_CSET;
    st_o.wr_mask   = wr_en_i && sel_o == REG_MASK;
    st_o.wr_mset   = wr_en_i && sel_o == REG_MSET;
    st_o.wr_mclr   = wr_en_i && sel_o == REG_MCLR;
    st_o.rd_cause  = rd_en_i && sel_o == REG_CAUSE;
    st_o.rd_mcause = rd_en_i && sel_o == REG_MCAUSE;
  end

  // R2: a write reaches at most one register
  a_r2_one_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({st_o.wr_ctl, st_o.wr_cause, st_o.wr_mcause, st_o.wr_cset,
              st_o.wr_mask, st_o.wr_mset, st_o.wr_mclr}));

endmodule

// File: rtl/intc_cfg.sv
module intc_cfg
  import intc_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  strobe_t          st_i,
  input  logic [N_SRC-1:0] wr_data_i,
  output logic [N_SRC-1:0] ctl_o,
  output logic [N_SRC-1:0] mask_o
);
  logic [N_SRC-1:0] mask_n;

  always_comb begin
    mask_n = mask_o;
    if (st_i.wr_mask) mask_n = wr_data_i;
    if (st_i.wr_mset) mask_n = mask_o | wr_data_i;
    if (st_i.wr_mclr) mask_n = mask_o & ~wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_o  <= '0;
      mask_o <= '1;
    end else begin
      if (st_i.wr_ctl) ctl_o <= wr_data_i;
      mask_o <= mask_n;
    end
  end

  a_r9_mask_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_i.wr_mask |=> mask_o == $past(wr_data_i));

  a_r10_mask_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_i.wr_mset |=> (mask_o & $past(wr_data_i)) == $past(wr_data_i));

  a_r10_mask_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_i.wr_mclr |=> (mask_o & $past(wr_data_i)) == '0);

  a_r10_mask_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i.wr_mset || st_i.wr_mclr) |=>
      ((mask_o ^ $past(mask_o)) & ~$past(wr_data_i)) == '0);

endmodule

// File: rtl/intc_cause.sv
module intc_cause
  import intc_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  strobe_t          st_i,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] wr_data_i,
  input  logic [N_SRC-1:0] ctl_i,
  input  logic [N_SRC-1:0] mask_i,
  output logic [N_SRC-1:0] cause_o
);
  logic [N_SRC-1:0] cause_n;

  for (genvar b = 0; b < N_SRC; b++) begin : g_bit
    logic clr_b, set_b, vis_b;
    assign vis_b = ~mask_i[b];
    // write-one clears only in W1C mode, read clears only in COR mode
    assign clr_b = (~ctl_i[b] & wr_data_i[b] & (st_i.wr_cause | (st_i.wr_mcause & vis_b)))
                 | ( ctl_i[b] & (st_i.rd_cause | (st_i.rd_mcause & vis_b)));
    assign set_b = src_i[b] | (st_i.wr_cset & wr_data_i[b]);
    // set has priority: hardware event beats same-cycle clear
    assign cause_n[b] = set_b | (cause_o[b] & ~clr_b);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_o <= '0;
    else         cause_o <= cause_n;
  end

  a_r3_r11_src_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src_i) |=> (cause_o & $past(src_i)) == $past(src_i));

  a_r8_sw_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_i.wr_cset |=> (cause_o & $past(wr_data_i)) == $past(wr_data_i));

  a_r4_w1c_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_i.wr_cause |=> (cause_o & $past(wr_data_i & ~ctl_i & ~src_i)) == '0);

  a_r5_cor_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i.rd_cause && !st_i.wr_cset) |=> (cause_o & $past(ctl_i & ~src_i)) == '0);

  a_r7_masked_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i.rd_mcause || st_i.wr_mcause) |=>
      (($past(cause_o & mask_i)) & ~cause_o) == '0);

endmodule

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [N_SRC-1:0]  wr_data_i,
  input  logic              rd_en_i,
  output logic [N_SRC-1:0]  rd_data_o,
  output logic              irq_o
);
  reg_sel_e         sel;
  strobe_t          st;
  logic [N_SRC-1:0] ctl, mask, cause, pend, rd_mux;

  intc_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .sel_o   (sel),
    .st_o    (st)
  );

  intc_cfg #(.N_SRC(N_SRC)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .st_i      (st),
    .wr_data_i (wr_data_i),
    .ctl_o     (ctl),
    .mask_o    (mask)
  );

  intc_cause #(.N_SRC(N_SRC)) u_cause (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .st_i      (st),
    .src_i     (src_i),
    .wr_data_i (wr_data_i),
    .ctl_i     (ctl),
    .mask_i    (mask),
    .cause_o   (cause)
  );

  assign pend = cause & ~mask;

  always_comb begin
    unique case (sel)
      REG_CTL:    rd_mux = ctl;
      REG_CAUSE:  rd_mux = cause;
      REG_MCAUSE: rd_mux = pend;
      REG_MASK:   rd_mux = mask;
      default:    rd_mux = '0;  // write-only aliases and holes
    endcase
  end

  assign rd_data_o = rd_en_i ? rd_mux : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |pend;
  end

  a_r12_irq_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_o == $past(|(cause & ~mask)));

  a_r6_mview_subset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && sel == REG_MCAUSE) |-> (rd_data_o & mask) == '0);

endmodule

// File: tb/intc_bank_bench.sv
module intc_bank_bench;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  src = '0;
  logic [4:0]    addr = '0;
  logic          we = 1'b0, re = 1'b0;
  logic [N-1:0]  wd = '0;
  logic [N-1:0]  rd_data_o;
  logic          irq_o;

  int n_cmp = 0, n_bad = 0;
  logic [N-1:0] cause_m = '0, ctl_m = '0, mask_m = '1;

  always #4 clk = ~clk;  // 125 MHz

  intc_bank #(.N_SRC(N), .ADDR_W(5)) u_intc_bank (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src), .addr_i(addr),
    .wr_en_i(we), .wr_data_i(wd), .rd_en_i(re),
    .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] mread(input logic [4:0] a);
    if (a[1:0] != 2'b00) return '0;
    case (a[4:2])
      3'd0: return ctl_m;
      3'd1: return cause_m;
      3'd2: return cause_m & ~mask_m;
      3'd4: return mask_m;
      default: return '0;
    endcase
  endfunction

  task automatic op(input string tag, input logic w, input logic r,
                    input logic [4:0] a, input logic [N-1:0] d, input logic [N-1:0] s);
    logic [N-1:0] clr, nmask;
    logic         old_irq, ok;
    @(negedge clk);
    we = w; re = r; addr = a; wd = d; src = s;
    #1;
    if (r) chk(tag, rd_data_o, mread(a));
    old_irq = |(cause_m & ~mask_m);
    ok = (a[1:0] == 2'b00) && (a[4:2] != 3'd7);
    clr = '0; nmask = mask_m;
    if (w && ok && a[4:2] == 3'd1) clr |= d & ~ctl_m;
    if (w && ok && a[4:2] == 3'd2) clr |= d & ~ctl_m & ~mask_m;
    if (r && ok && a[4:2] == 3'd1) clr |= ctl_m;
    if (r && ok && a[4:2] == 3'd2) clr |= ctl_m & ~mask_m;
    if (w && ok && a[4:2] == 3'd4) nmask = d;
    if (w && ok && a[4:2] == 3'd5) nmask = mask_m | d;
    if (w && ok && a[4:2] == 3'd6) nmask = mask_m & ~d;
    @(posedge clk);
    #1;
    chk("R12 irq latency", {31'd0, irq_o}, {31'd0, old_irq});
    cause_m = (cause_m & ~clr) | s | ((w && ok && a[4:2] == 3'd3) ? d : '0);
    if (w && ok && a[4:2] == 3'd0) ctl_m = d;
    mask_m = nmask;
    we = 0; re = 0; src = '0; wd = '0;
  endtask

  task automatic wr(input string t, input logic [4:0] a, input logic [N-1:0] d);
    op(t, 1'b1, 1'b0, a, d, '0);
  endtask
  task automatic rd(input string t, input logic [4:0] a);
    op(t, 1'b0, 1'b1, a, '0, '0);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", {31'd0, irq_o}, '0);
    rst_ni = 1'b1;
    // R1, R2: reset values and the read map
    for (int a = 0; a < 32; a += 4) rd("R1 R2 reset read", 5'(a));
    rd("R2 misaligned", 5'h12);
    wr("R2 hole write", 5'h1C, 32'hFFFF_FFFF);
    wr("R2 misaligned write", 5'h11, 32'h0);
    rd("R2 mask kept", 5'h10);
    // R9 direct mask
    wr("R9", 5'h10, 32'h0F0F_0F0F);
    rd("R9 readback", 5'h10);
    // R8 and R6
    wr("R8 cset", 5'h0C, 32'hA5A5_0001);
    rd("R8 cause", 5'h04);
    rd("R6 masked view", 5'h08);
    rd("R2 cset reads zero", 5'h0C);
    op("R12 idle", 1'b0, 1'b0, 5'h0, '0, '0);
    // R4 write-one-to-clear, zeros ignored
    wr("R4 zero write", 5'h04, 32'h0);
    rd("R4 after zero", 5'h04);
    wr("R4 w1c", 5'h04, 32'h0000_0001);
    rd("R4 after clear", 5'h04);
    // R5 clear-on-read, write-one ignored
    wr("R5 ctl", 5'h00, 32'hFFFF_0000);
    wr("R5 w1 ignored", 5'h04, 32'hFFFF_0000);
    rd("R5 cor read", 5'h04);
    rd("R5 after cor", 5'h04);
    // R7 masked view clears only visible bits
    wr("R7 cset", 5'h0C, 32'hFFFF_FFFF);
    wr("R7 mask", 5'h10, 32'h00FF_00FF);
    rd("R7 masked cor", 5'h08);
    wr("R7 ctl off", 5'h00, 32'h0);
    rd("R7 raw after", 5'h04);
    wr("R7 masked w1c", 5'h08, 32'hFFFF_FFFF);
    rd("R7 raw after w1c", 5'h04);
    // R10 aliases
    wr("R10 mask", 5'h10, 32'h0);
    wr("R10 mset", 5'h14, 32'h0000_00F0);
    rd("R10 after set", 5'h10);
    wr("R10 mclr", 5'h18, 32'h0000_0030);
    rd("R10 after clr", 5'h10);
    wr("R10 zero set", 5'h14, 32'h0);
    wr("R10 zero clr", 5'h18, 32'h0);
    rd("R10 unchanged", 5'h10);
    rd("R2 mset reads zero", 5'h14);
    rd("R2 mclr reads zero", 5'h18);
    // R11 hardware wins over same-cycle clear
    wr("R11 ctl", 5'h00, 32'h0000_0010);
    wr("R11 cset", 5'h0C, 32'h0000_0018);
    op("R11 w1c race", 1'b1, 1'b0, 5'h04, 32'h0000_0008, 32'h0000_0008);
    op("R11 cor race", 1'b0, 1'b1, 5'h04, '0, 32'h0000_0010);
    rd("R11 both kept", 5'h04);
    // per-bit sweep: mixed control and mask patterns
    wr("R5 sweep ctl", 5'h00, 32'h3C3C_A5A5);
    wr("R9 sweep mask", 5'h10, 32'h0F0F_3355);
    rd("R4 R5 drain", 5'h04);
    wr("R4 drain", 5'h04, 32'hFFFF_FFFF);
    for (int b = 0; b < N; b++) begin
      op("R3 pulse", 1'b0, 1'b0, 5'h00, '0, N'(1) << b);
      op("R3 idle", 1'b0, 1'b0, 5'h00, '0, '0);
      rd("R6 R7 masked read", 5'h08);
      rd("R3 R5 raw read", 5'h04);
      wr("R4 raw w1c", 5'h04, N'(1) << b);
      rd("R4 R5 raw after", 5'h04);
      wr("R8 sweep set", 5'h0C, N'(1) << b);
      wr("R7 masked w1c", 5'h08, N'(1) << b);
      rd("R7 masked after", 5'h08);
      rd("R7 raw after", 5'h04);
      wr("R9 unmask", 5'h18, N'(1) << b);
      rd("R7 unmasked read", 5'h08);
      wr("R4 cleanup", 5'h04, '1);
      rd("R5 cleanup", 5'h04);
      wr("R10 remask", 5'h10, 32'h0F0F_3355);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule